// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the eight interrupt causes of a two-channel UART into one status byte and combines that byte with a software-written mask byte. The result drives a single active-low interrupt pin. The UART datapaths and the counter/timer are not part of the block. Each of them reaches it as a set pulse, a clear pulse or a level.

The status bits do not all behave alike. Six of them are sticky. Each sticky bit is set by its source event and cleared only by one particular CPU action:

- a read of the input-change register,
- a per-channel break-acknowledge command,
- a receive-data read,
- a stop-counter command.

The two transmitter-ready bits are not stored. They follow their channel's transmitter-ready level. The mask decides only whether a status bit can pull the pin low. The status byte is always shown without the mask applied.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the status byte reads 0x00 (with both transmitter-ready levels low), the mask byte reads 0x00, and `irq_n` is high.
- R2: `irq_n` is low exactly when some bit position is 1 in both the status byte and the mask byte.
- R3: A status bit whose mask bit is 0 never affects `irq_n`.
- R4: `status` always shows the unmasked status, for every mask value.
- R5: Bit 7 (input change) is set one clock after `ev_in_change` and cleared one clock after `rd_in_change`.
- R6: Bit 6 (channel B break change) and bit 2 (channel A break change) are set one clock after that channel's break event. Each is cleared only by that channel's break-acknowledge strobe. Every other clear strobe leaves it unchanged.
- R7: Bit 5 (channel B receive) and bit 1 (channel A receive) are set one clock after that channel's receive event and cleared one clock after that channel's receive-data read.
- R8: Bit 4 equals `tx_rdy_b` and bit 0 equals `tx_rdy_a` in the same cycle, with no register in between.
- R9: Bit 3 (counter ready) is set one clock after `ev_ctr_ready` and cleared one clock after `cmd_ctr_stop`.
- R10: If a set event and a clear strobe reach the same sticky bit in the same cycle, the bit is 1 afterwards.
- R11: When `mask_we` is high, `mask` takes the value of `mask_wdata` at the next clock edge. Otherwise `mask` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in_change | input | 1 | Enabled change seen on input pins 0 to 3 |
| rd_in_change | input | 1 | CPU read of the input-change register |
| ev_brk_a | input | 1 | Channel A break start or end |
| cmd_brk_ack_a | input | 1 | Channel A break-acknowledge command |
| ev_brk_b | input | 1 | Channel B break start or end |
| cmd_brk_ack_b | input | 1 | Channel B break-acknowledge command |
| ev_rx_a | input | 1 | Channel A receive-ready or FIFO-full event |
| rd_rx_a | input | 1 | CPU read of channel A receive data |
| ev_rx_b | input | 1 | Channel B receive-ready or FIFO-full event |
| rd_rx_b | input | 1 | CPU read of channel B receive data |
| ev_ctr_ready | input | 1 | Counter reached its terminal count or completed a timer cycle |
| cmd_ctr_stop | input | 1 | Stop-counter command |
| tx_rdy_a | input | 1 | Channel A transmitter-ready level |
| tx_rdy_b | input | 1 | Channel B transmitter-ready level |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| status | output | 8 | Unmasked interrupt status byte |
| mask | output | 8 | Current mask byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The main check is a full sweep over all 256 mask values crossed with all 256 status values. Each status value is built in one cycle by firing every clear strobe together with the chosen set events. This sweep separates a wrong AND or OR reduction, a swapped bit, and any leak of the mask into the readback. It also tests set priority on all six sticky bits together.

Directed sequences cover the rest:
- each sticky bit is cleared alone;
- a break bit is checked against every foreign clear strobe, which shows up any cross-wiring of clears;
- a transmitter-ready level is toggled between clock edges, which shows whether the mirror bits are registered by mistake.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 8;

  localparam int B_TX_A    = 0;
  localparam int B_RX_A    = 1;
  localparam int B_BRK_A   = 2;
  localparam int B_CTR     = 3;
  localparam int B_TX_B    = 4;
  localparam int B_RX_B    = 5;
  localparam int B_BRK_B   = 6;
  localparam int B_IN_CHG  = 7;

  // Positions held in a flop; the others mirror a level.
  localparam logic [NSRC-1:0] STICKY_SEL =
    NSRC'((1 << B_RX_A) | (1 << B_BRK_A) | (1 << B_CTR) |
          (1 << B_RX_B) | (1 << B_BRK_B) | (1 << B_IN_CHG));

  typedef logic [NSRC-1:0] src_vec_t;

  // Set has priority over clear.
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic irq_active(input src_vec_t st, input src_vec_t msk);
    return |(st & msk);
  endfunction
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
  import uart_irq_pkg::*;
(
  input  logic     ev_in_change,
  input  logic     rd_in_change,
  input  logic     ev_brk_a,
  input  logic     cmd_brk_ack_a,
  input  logic     ev_brk_b,
  input  logic     cmd_brk_ack_b,
  input  logic     ev_rx_a,
  input  logic     rd_rx_a,
  input  logic     ev_rx_b,
  input  logic     rd_rx_b,
  input  logic     ev_ctr_ready,
  input  logic     cmd_ctr_stop,
  input  logic     tx_rdy_a,
  input  logic     tx_rdy_b,
  output src_vec_t set_v,
  output src_vec_t clr_v,
  output src_vec_t lvl_v
);
  always_comb begin
    set_v = '0;
    clr_v = '0;
    lvl_v = '0;
    set_v[B_IN_CHG] = ev_in_change;  clr_v[B_IN_CHG] = rd_in_change;
    set_v[B_BRK_A]  = ev_brk_a;      clr_v[B_BRK_A]  = cmd_brk_ack_a;
    set_v[B_BRK_B]  = ev_brk_b;      clr_v[B_BRK_B]  = cmd_brk_ack_b;
    set_v[B_RX_A]   = ev_rx_a;       clr_v[B_RX_A]   = rd_rx_a;
    set_v[B_RX_B]   = ev_rx_b;       clr_v[B_RX_B]   = rd_rx_b;
    set_v[B_CTR]    = ev_ctr_ready;  clr_v[B_CTR]    = cmd_ctr_stop;
    lvl_v[B_TX_A]   = tx_rdy_a;
    lvl_v[B_TX_B]   = tx_rdy_b;
  end
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r7_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  src_vec_t wdata,
  output src_vec_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  a_r11_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_in_change,
  input  logic            rd_in_change,
  input  logic            ev_brk_a,
  input  logic            cmd_brk_ack_a,
  input  logic            ev_brk_b,
  input  logic            cmd_brk_ack_b,
  input  logic            ev_rx_a,
  input  logic            rd_rx_a,
  input  logic            ev_rx_b,
  input  logic            rd_rx_b,
  input  logic            ev_ctr_ready,
  input  logic            cmd_ctr_stop,
  input  logic            tx_rdy_a,
  input  logic            tx_rdy_b,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic            irq_n
);
  src_vec_t set_v, clr_v, lvl_v;
  src_vec_t status_w, mask_w;
  logic     hit_w;

  irq_event_map u_map (
    .ev_in_change (ev_in_change),
    .rd_in_change (rd_in_change),
    .ev_brk_a     (ev_brk_a),
    .cmd_brk_ack_a(cmd_brk_ack_a),
    .ev_brk_b     (ev_brk_b),
    .cmd_brk_ack_b(cmd_brk_ack_b),
    .ev_rx_a      (ev_rx_a),
    .rd_rx_a      (rd_rx_a),
    .ev_rx_b      (ev_rx_b),
    .rd_rx_b      (rd_rx_b),
    .ev_ctr_ready (ev_ctr_ready),
    .cmd_ctr_stop (cmd_ctr_stop),
    .tx_rdy_a     (tx_rdy_a),
    .tx_rdy_b     (tx_rdy_b),
    .set_v        (set_v),
    .clr_v        (clr_v),
    .lvl_v        (lvl_v)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (STICKY_SEL[i]) begin : g_sticky
      irq_sticky_bit u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_v[i]),
        .clr_i(clr_v[i]),
        .q_o  (status_w[i])
      );
    end else begin : g_mirror
      assign status_w[i] = lvl_v[i];
    end
  end

  irq_mask_reg u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mask_we),
    .wdata(mask_wdata),
    .q    (mask_w)
  );

  assign hit_w  = irq_active(status_w, mask_w);
  assign status = status_w;
  assign mask   = mask_w;
  assign irq_n  = ~hit_w;

  // R3: the pin only moves when status or mask moved.
  a_r3_pin_follows_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_n) |-> (!$stable(status_w) || !$stable(mask_w)));
  // R2: a zero mask keeps the pin high.
  a_r2_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> irq_n);
  // R6: a channel A break acknowledge leaves channel B's break bit untouched.
  a_r6_brk_b_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w[B_BRK_B] && !cmd_brk_ack_b) |=> status_w[B_BRK_B]);
  // R5: an input-change read with no new event clears bit 7.
  a_r5_in_change_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in_change && !ev_in_change) |=> !status_w[B_IN_CHG]);
endmodule

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_in_change = 0, rd_in_change = 0;
  logic ev_brk_a = 0, cmd_brk_ack_a = 0, ev_brk_b = 0, cmd_brk_ack_b = 0;
  logic ev_rx_a = 0, rd_rx_a = 0, ev_rx_b = 0, rd_rx_b = 0;
  logic ev_ctr_ready = 0, cmd_ctr_stop = 0;
  logic tx_rdy_a = 0, tx_rdy_b = 0;
  logic mask_we = 0;
  logic [7:0] mask_wdata = '0;
  logic [7:0] status, mask;
  logic irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_unit u_dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drop_all();
    ev_in_change = 0; rd_in_change = 0; ev_brk_a = 0; cmd_brk_ack_a = 0;
    ev_brk_b = 0; cmd_brk_ack_b = 0; ev_rx_a = 0; rd_rx_a = 0;
    ev_rx_b = 0; rd_rx_b = 0; ev_ctr_ready = 0; cmd_ctr_stop = 0;
    mask_we = 0;
  endtask

  // Drive all clears and the set events for the wanted status s.
  task automatic force_status(input logic [7:0] s);
    rd_in_change = 1; cmd_brk_ack_a = 1; cmd_brk_ack_b = 1;
    rd_rx_a = 1; rd_rx_b = 1; cmd_ctr_stop = 1;
    ev_in_change = s[7]; ev_brk_b = s[6]; ev_rx_b = s[5];
    ev_ctr_ready = s[3]; ev_brk_a = s[2]; ev_rx_a = s[1];
    tx_rdy_b = s[4]; tx_rdy_a = s[0];
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    drop_all();
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_we = 1; mask_wdata = m;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 mask", mask, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    check("R1 status after release", status, 8'h00);
    check("R1 irq_n after release", {7'd0, irq_n}, 8'h01);

    // R2 R3 R4 R10 R11: full sweep of mask x status
    for (int m = 0; m < 256; m++) begin
      write_mask(8'(m));
      check("R11 mask readback", mask, 8'(m));
      for (int s = 0; s < 256; s++) begin
        force_status(8'(s));
        step();
        check("R4 R10 status", status, 8'(s));
        check("R2 R3 irq_n", {7'd0, irq_n}, {7'd0, ((8'(s) & 8'(m)) == 8'h00)});
      end
    end
    force_status(8'h00); step();
    check("R3 zeroed", status, 8'h00);

    // R11 hold without strobe
    mask_wdata = 8'h5A; step();
    check("R11 mask hold", mask, 8'hFF);

    // R5
    ev_in_change = 1; step();
    check("R5 set", status, 8'h80);
    check("R2 irq low", {7'd0, irq_n}, 8'h00);
    step();
    check("R5 sticky", status, 8'h80);
    rd_in_change = 1; step();
    check("R5 clear", status, 8'h00);

    // R6 channel B break survives every foreign clear
    ev_brk_b = 1; step();
    check("R6 set B", status, 8'h40);
    rd_in_change = 1; cmd_brk_ack_a = 1; rd_rx_a = 1; rd_rx_b = 1; cmd_ctr_stop = 1;
    step();
    check("R6 foreign clears", status, 8'h40);
    cmd_brk_ack_b = 1; step();
    check("R6 clear B", status, 8'h00);
    ev_brk_a = 1; step();
    check("R6 set A", status, 8'h04);
    cmd_brk_ack_b = 1; step();
    check("R6 A holds on B ack", status, 8'h04);
    cmd_brk_ack_a = 1; step();
    check("R6 clear A", status, 8'h00);

    // R7
    ev_rx_a = 1; ev_rx_b = 1; step();
    check("R7 set both", status, 8'h22);
    rd_rx_b = 1; step();
    check("R7 clear B", status, 8'h02);
    rd_rx_a = 1; step();
    check("R7 clear A", status, 8'h00);

    // R8 combinational mirror between edges
    #1 tx_rdy_b = 1; #1;
    check("R8 tx_b mirror", status, 8'h10);
    tx_rdy_a = 1; #1;
    check("R8 tx_a mirror", status, 8'h11);
    tx_rdy_b = 0; tx_rdy_a = 0; #1;
    check("R8 mirror low", status, 8'h00);
    @(negedge clk);

    // R9
    ev_ctr_ready = 1; step();
    check("R9 set", status, 8'h08);
    cmd_ctr_stop = 1; step();
    check("R9 clear", status, 8'h00);

    // R10 per-bit simultaneous set/clear
    ev_ctr_ready = 1; cmd_ctr_stop = 1; step();
    check("R10 set beats stop", status, 8'h08);

    // R3 masked bit alone leaves pin high
    write_mask(8'hF7);
    check("R3 masked ctr", {7'd0, irq_n}, 8'h01);
    check("R4 unmasked readback", status, 8'h08);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end
endmodule